// File: doc/BRIEF.md
# Add/Subtract Unit with Relational Predicates

This block is a purely combinational two's-complement adder/subtractor of parameterized width. A single control bit selects between the sum A+B and the difference A−B. Subtraction reuses the same adder: the B operand is bitwise inverted and a carry-in of one is injected, so both operations share one carry chain.

Alongside the result, the unit reports four condition flags (zero, negative, carry out and signed overflow). A decoder turns those four flags into ten relational predicates, six signed and four unsigned. To compare two operands, a client selects subtraction and reads the predicate it needs. No magnitude comparator is built for this; every relation comes from the flags of the one subtraction. When the unit adds, the predicates still follow the same flag formulas but carry no relational meaning.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_i`=0 the result `sum_o` equals (A+B) mod 2^W; with `sub_i`=1 it equals (A−B) mod 2^W.
- R2: `zero_o` is 1 exactly when every bit of `sum_o` is 0.
- R3: `neg_o` equals the most significant bit of `sum_o`.
- R4: `carry_o` is the carry out of bit W−1 of A + B' + `sub_i`, where B' is B when adding and ~B when subtracting. In subtract mode it is therefore 1 exactly when A ≥ B as unsigned numbers (no borrow).
- R5: `ovf_o` is 1 exactly when the true signed result of the selected operation lies outside [−2^(W−1), 2^(W−1)−1].
- R6: In subtract mode `eq_o` is 1 iff A = B, and `ne_o` is its complement.
- R7: In subtract mode `lt_o` is 1 iff A < B as signed numbers, and `ge_o` is its complement.
- R8: In subtract mode `le_o` is 1 iff A ≤ B as signed numbers, and `gt_o` is its complement.
- R9: In subtract mode `ltu_o` is 1 iff A < B as unsigned numbers, and `geu_o` is its complement.
- R10: In subtract mode `leu_o` is 1 iff A ≤ B as unsigned numbers, and `gtu_o` is its complement.
- R11: In add mode the predicates follow the flag formulas: eq=Z, ne=!Z, lt=N^V, le=Z|(N^V), ge=!(N^V), gt=!(Z|(N^V)), ltu=!C, leu=!C|Z, geu=C, gtu=C&!Z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| sum_o | output | W | Result modulo 2^W |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result sign bit |
| carry_o | output | 1 | Carry out of the top bit |
| ovf_o | output | 1 | Signed overflow |
| eq_o | output | 1 | Equal |
| ne_o | output | 1 | Not equal |
| lt_o | output | 1 | Signed less than |
| le_o | output | 1 | Signed less or equal |
| ge_o | output | 1 | Signed greater or equal |
| gt_o | output | 1 | Signed greater than |
| ltu_o | output | 1 | Unsigned less than |
| leu_o | output | 1 | Unsigned less or equal |
| geu_o | output | 1 | Unsigned greater or equal |
| gtu_o | output | 1 | Unsigned greater than |

## Verification
The bench sweeps every operand pair at the default 8-bit width in both modes, so it covers each hard corner: the most negative value minus one, the largest positive plus one, all-ones plus one, and equal operands. An overflow taken only from operand signs without the inverted B would mislabel subtractions. A carry read as a borrow would swap every unsigned predicate. Using N alone instead of N^V for the signed predicates breaks exactly the comparisons that overflow, such as −128 against 1. A missing carry-in of one would leave every difference off by one.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } cc_flags_t;

    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic le;
        logic ge;
        logic gt;
        logic ltu;
        logic leu;
        logic geu;
        logic gtu;
    } rel_preds_t;

    // Flag-to-relation decode; meaningful after a subtraction A-B.
    function automatic rel_preds_t decode_rel(input cc_flags_t f);
        rel_preds_t p;
        logic       slt;
        slt   = f.neg ^ f.ovf;
        p.eq  = f.zero;
        p.ne  = ~f.zero;
        p.lt  = slt;
        p.le  = f.zero | slt;
        p.ge  = ~slt;
        p.gt  = ~(f.zero | slt);
        p.ltu = ~f.carry;
        p.leu = ~f.carry | f.zero;
        p.geu = f.carry;
        p.gtu = f.carry & ~f.zero;
        return p;
    endfunction

endpackage

// File: rtl/addsub_operand.sv
`timescale 1ns/1ps
module addsub_operand
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] b_i,
    input  addsub_op_e   op_i,
    output logic [W-1:0] b_eff_o,
    output logic         cin_o
);
    logic invert;
    assign invert = (op_i == OP_SUB);
    assign cin_o  = invert;

    for (genvar i = 0; i < W; i++) begin : g_inv
        assign b_eff_o[i] = b_i[i] ^ invert;
    end
endmodule

// File: rtl/addsub_ripple.sv
`timescale 1ns/1ps
module addsub_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         cmsb_o
);
    localparam int WX = W + 1;

    always_comb begin
        logic c;
        c      = cin_i;
        cmsb_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i == W - 1) cmsb_o = c;
            sum_o[i] = a_i[i] ^ b_i[i] ^ c;
            c        = (a_i[i] & b_i[i]) | (c & (a_i[i] ^ b_i[i]));
        end
        cout_o = c;
    end

    logic [WX-1:0] wide_total;
    assign wide_total = {1'b0, a_i} + {1'b0, b_i} + WX'(cin_i);

    always_comb begin
        AST_RIPPLE_TOTAL: assert ({cout_o, sum_o} == wide_total)
            else $error("ripple chain disagrees with wide sum"); // R1
    end
endmodule

// File: rtl/addsub_flags.sv
`timescale 1ns/1ps
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sum_i,
    input  logic         cout_i,
    input  logic         cmsb_i,
    output cc_flags_t    flags_o
);
    assign flags_o.zero  = ~|sum_i;
    assign flags_o.neg   = sum_i[W-1];
    assign flags_o.carry = cout_i;
    assign flags_o.ovf   = cmsb_i ^ cout_i;
endmodule

// File: rtl/addsub_reldec.sv
`timescale 1ns/1ps
module addsub_reldec
    import addsub_pkg::*;
(
    input  cc_flags_t  flags_i,
    output rel_preds_t preds_o
);
    assign preds_o = decode_rel(flags_i);
endmodule

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         zero_o,
    output logic         neg_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         eq_o,
    output logic         ne_o,
    output logic         lt_o,
    output logic         le_o,
    output logic         ge_o,
    output logic         gt_o,
    output logic         ltu_o,
    output logic         leu_o,
    output logic         geu_o,
    output logic         gtu_o
);
    localparam int MSB = W - 1;

    addsub_op_e op;
    logic [W-1:0] b_eff;
    logic         cin;
    logic         cout;
    logic         cmsb;
    logic [W-1:0] sum;
    cc_flags_t    flags;
    rel_preds_t   preds;

    assign op = addsub_op_e'(sub_i);

    addsub_operand #(.W(W)) u_operand (
        .b_i     (b_i),
        .op_i    (op),
        .b_eff_o (b_eff),
        .cin_o   (cin)
    );

    addsub_ripple #(.W(W)) u_ripple (
        .a_i    (a_i),
        .b_i    (b_eff),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout),
        .cmsb_o (cmsb)
    );

    addsub_flags #(.W(W)) u_flags (
        .sum_i   (sum),
        .cout_i  (cout),
        .cmsb_i  (cmsb),
        .flags_o (flags)
    );

    addsub_reldec u_reldec (
        .flags_i (flags),
        .preds_o (preds)
    );

    assign sum_o   = sum;
    assign zero_o  = flags.zero;
    assign neg_o   = flags.neg;
    assign carry_o = flags.carry;
    assign ovf_o   = flags.ovf;
    assign eq_o    = preds.eq;
    assign ne_o    = preds.ne;
    assign lt_o    = preds.lt;
    assign le_o    = preds.le;
    assign ge_o    = preds.ge;
    assign gt_o    = preds.gt;
    assign ltu_o   = preds.ltu;
    assign leu_o   = preds.leu;
    assign geu_o   = preds.geu;
    assign gtu_o   = preds.gtu;

    // Operand-level cross checks against the flag path.
    logic [W-1:0] ref_result;
    logic         sign_ovf;
    assign ref_result = sub_i ? (a_i - b_i) : (a_i + b_i);
    assign sign_ovf   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

    always_comb begin
        AST_RESULT_VALUE: assert (sum_o == ref_result)
            else $error("result mismatch"); // R1
        AST_CARRY_NO_BORROW: assert (!sub_i || (carry_o == (a_i >= b_i)))
            else $error("carry is not no-borrow"); // R4
        AST_OVF_SIGNS: assert (ovf_o == sign_ovf)
            else $error("overflow disagrees with operand signs"); // R5
        AST_EQ_SUB: assert (!sub_i || (eq_o == (a_i == b_i)))
            else $error("eq wrong"); // R6
        AST_LT_SIGNED: assert (!sub_i || (lt_o == ($signed(a_i) < $signed(b_i))))
            else $error("signed lt wrong"); // R7
        AST_GT_SIGNED: assert (!sub_i || (gt_o == ($signed(a_i) > $signed(b_i))))
            else $error("signed gt wrong"); // R8
        AST_LTU_SUB: assert (!sub_i || (ltu_o == (a_i < b_i)))
            else $error("unsigned lt wrong"); // R9
        AST_GTU_SUB: assert (!sub_i || (gtu_o == (a_i > b_i)))
            else $error("unsigned gt wrong"); // R10
    end
endmodule

// File: tb/addsub_unit_test.sv
`timescale 1ns/1ps
module addsub_unit_test;
    localparam int W = 8;
    localparam int WATCHDOG_CYCLES = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [W-1:0] a, b, sum;
    logic sub;
    logic zero, neg, carry, ovf;
    logic eq, ne, lt, le, ge, gt, ltu, leu, geu, gtu;

    addsub_unit #(.W(W)) uut (
        .a_i(a), .b_i(b), .sub_i(sub),
        .sum_o(sum), .zero_o(zero), .neg_o(neg), .carry_o(carry), .ovf_o(ovf),
        .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le), .ge_o(ge), .gt_o(gt),
        .ltu_o(ltu), .leu_o(leu), .geu_o(geu), .gtu_o(gtu)
    );

    typedef struct packed {
        logic [W-1:0] sum;
        logic [3:0]   flags;   // zero, neg, carry, ovf
        logic [9:0]   preds;   // eq ne lt le ge gt ltu leu geu gtu
        logic         sub;
    } exp_t;

    exp_t scoreboard[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
        exp_t e;
        logic [W-1:0] yb;
        logic [W:0]   full;
        logic z, n, c, v;
        int sx, sy, sr;
        yb   = s ? ~y : y;
        full = {1'b0, x} + {1'b0, yb} + (W+1)'(s);
        sx   = $signed(x);
        sy   = $signed(y);
        sr   = s ? (sx - sy) : (sx + sy);
        z    = (full[W-1:0] == '0);
        n    = full[W-1];
        c    = full[W];
        v    = (sr > (2**(W-1) - 1)) || (sr < -(2**(W-1)));
        e.sum   = s ? (x - y) : (x + y);
        e.flags = {z, n, c, v};
        e.sub   = s;
        if (s)
            e.preds = {x == y, x != y, sx < sy, sx <= sy, sx >= sy, sx > sy,
                       x < y, x <= y, x >= y, x > y};
        else
            e.preds = {z, !z, n ^ v, z | (n ^ v), !(n ^ v), !(z | (n ^ v)),
                       !c, !c | z, c, c & !z};
        return e;
    endfunction

    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
        @(posedge clk);
        a   <= x;
        b   <= y;
        sub <= s;
        scoreboard.push_back(model(x, y, s));
    endtask

    function automatic string pred_req(input int idx, input logic s);
        if (!s) return "R11";
        case (idx)
            9, 8:    return "R6";
            7, 5:    return "R7";
            6, 4:    return "R8";
            3, 1:    return "R9";
            default: return "R10";
        endcase
    endfunction

    // Monitor: compare half a cycle after each drive.
    initial begin
        forever begin
            @(negedge clk);
            if (scoreboard.size() > 0) begin
                exp_t e;
                logic [9:0] got_p;
                e = scoreboard.pop_front();
                got_p = {eq, ne, lt, le, ge, gt, ltu, leu, geu, gtu};
                check(sum == e.sum, "R1", sum, e.sum);
                check(zero == e.flags[3], "R2", zero, e.flags[3]);
                check(neg == e.flags[2], "R3", neg, e.flags[2]);
                check(carry == e.flags[1], "R4", carry, e.flags[1]);
                check(ovf == e.flags[0], "R5", ovf, e.flags[0]);
                for (int i = 0; i < 10; i++)
                    if (got_p[i] !== e.preds[i])
                        check(1'b0, pred_req(i, e.sub), got_p, e.preds);
                check(got_p == e.preds, e.sub ? "R6" : "R11", got_p, e.preds);
            end
        end
    end

    initial begin
        a = '0; b = '0; sub = 1'b0;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // Reset state with idle operands: 0+0.
        check(sum == '0, "R1", sum, 0);
        check(zero == 1'b1, "R2", zero, 1);
        check(carry == 1'b0, "R4", carry, 0);
        // Directed corners.
        drive(8'h7F, 8'h01, 1'b0);   // R5 positive overflow on add
        drive(8'h80, 8'h01, 1'b1);   // R5 overflow on subtract, R7 -128 < 1
        drive(8'hFF, 8'h01, 1'b0);   // R4 carry out, R2 zero result
        drive(8'h55, 8'h55, 1'b1);   // R6 equal, R4 no borrow
        drive(8'h00, 8'h00, 1'b1);   // R4 carry set for 0-0
        drive(8'h01, 8'hFF, 1'b1);   // R9 1 < 255 unsigned, R8 1 > -1 signed
        drive(8'h80, 8'h80, 1'b0);   // R5 negative overflow on add
        // Exhaustive sweep in both modes.
        for (int s = 0; s < 2; s++)
            for (int x = 0; x < 2**W; x++)
                for (int y = 0; y < 2**W; y++)
                    drive(W'(x), W'(y), s[0]);
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        for (cyc = 0; cyc < WATCHDOG_CYCLES && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule